// File: doc/BRIEF.md
# Virtual Page Hash Generator

This block turns a translation request into the primary hash used to index a hashed page table. Each request carries a segment identifier, the page-number bits of the effective address, a segment-size select and the page shift. The block builds the virtual page number in 4 KB units by placing the segment identifier above the in-segment page bits. It then applies the hash that belongs to the selected segment size, keeps the low 39 bits and places the result in one output register.

Requests enter on a valid/ready handshake, and the result leaves on a second one. A request whose page shift is below 12 produces no result. It raises a one-cycle error pulse instead. The caller applies the table-size mask and computes the group address. Both of those steps are outside this block, and so is the scrambling that produces the segment identifier.

Top module: `vpage_hash`

## Requirements
- R1: With `seg_1t` = 0 (256 MB segments) the page number is `(sid << 16) | ea_pn[15:0]`, truncated to 64 bits. The hash is `(vpn >> 16) ^ ((vpn & 0xFFFF) >> (page_shift - 12))`.
- R2: With `seg_1t` = 1 (1 TB segments) the page number is `(sid << 28) | ea_pn[27:0]`, truncated to 64 bits. With `s = vpn >> 28`, the hash is `s ^ (s << 25) ^ ((vpn & 0xFFFFFFF) >> (page_shift - 12))`.
- R3: `hash` carries only bits 38..0 of the computed value. Any higher bits are dropped.
- R4: If an accepted request has `page_shift` < 12, then `err` is 1 in the following cycle and `out_valid` stays 0 for that request. Otherwise `err` is 0.
- R5: An accepted request with a legal page shift shows up on `out_valid` and `hash` one clock later. When the output is taken and no new request is accepted, `out_valid` returns to 0.
- R6: While `out_valid` = 1 and `out_ready` = 0, `hash` and `out_valid` hold their values and `in_ready` is 0.
- R7: After reset, `out_valid` = 0, `err` = 0 and `in_ready` = 1.
- R8: A page shift of at least 12 plus the in-segment field width (28 for 256 MB, 40 for 1 TB) clears the page-index term entirely. The hash then depends only on the segment identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| sid | input | 52 | Segment identifier |
| ea_pn | input | 28 | Effective address bits 39..12 |
| seg_1t | input | 1 | 0 selects 256 MB segments, 1 selects 1 TB segments |
| page_shift | input | 6 | Log2 of the page size |
| out_valid | output | 1 | Hash present |
| out_ready | input | 1 | Consumer takes the hash |
| hash | output | 39 | Registered page-table hash |
| err | output | 1 | One-cycle pulse for a rejected page shift |

## Verification
The assertions assume that `out_ready` and the request fields are ordinary two-valued levels sampled at the clock edge. They also assume that the consumer may deassert `out_ready` at any time. They make no assumption about the request fields being held while `in_ready` is low. The stimulus changes inputs only on the falling edge. It sweeps page shifts from 0 to 45 for both segment sizes with pseudo-random identifiers and address bits. It also contains one stall episode in which a second request waits behind a held result.

// File: rtl/vpage_hash.sv
module vpage_hash #(
  parameter int SID_W  = 52,
  parameter int VPN_W  = 64,
  parameter int PS_W   = 6,
  parameter int HASH_W = 39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SID_W-1:0]  sid,
  input  logic [27:0]       ea_pn,
  input  logic              seg_1t,
  input  logic [PS_W-1:0]   page_shift,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HASH_W-1:0] hash,
  output logic              err
);
  localparam int PG_SHIFT = 12;
  localparam int LOW_S    = 28 - PG_SHIFT;
  localparam int LOW_L    = 40 - PG_SHIFT;
  localparam int FOLD     = 25;

  logic [VPN_W-1:0]  vpn_s, vpn_l, seg_l, idx_s, idx_l;
  logic [PS_W-1:0]   sh;
  logic [HASH_W-1:0] hash_s, hash_l, hash_d;
  logic              bad, take;

  assign sh     = page_shift - PS_W'(PG_SHIFT);
  assign bad    = page_shift < PS_W'(PG_SHIFT);
  assign vpn_s  = VPN_W'({sid, ea_pn[LOW_S-1:0]});
  assign vpn_l  = VPN_W'({sid, ea_pn[LOW_L-1:0]});
  assign idx_s  = VPN_W'(vpn_s[LOW_S-1:0]) >> sh;
  assign idx_l  = VPN_W'(vpn_l[LOW_L-1:0]) >> sh;
  assign seg_l  = vpn_l >> LOW_L;
  assign hash_s = HASH_W'((vpn_s >> LOW_S) ^ idx_s);
  assign hash_l = HASH_W'(seg_l ^ (seg_l << FOLD) ^ idx_l);
  assign hash_d = seg_1t ? hash_l : hash_s;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      err       <= 1'b0;
      hash      <= '0;
    end else begin
      err <= take && bad;
      if (take) begin
        out_valid <= !bad;
        if (!bad) hash <= hash_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vpage_hash_chk.sv
module vpage_hash_chk #(
  parameter int PS_W   = 6,
  parameter int HASH_W = 39
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [PS_W-1:0]   page_shift,
  input logic              out_valid,
  input logic              out_ready,
  input logic [HASH_W-1:0] hash,
  input logic              err
);
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(hash));

  assert_accept_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && page_shift >= PS_W'(12) |=> out_valid && !err);

  assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  assert_bad_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && page_shift < PS_W'(12) |=> err && !out_valid);

  assert_err_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !err);

  assert_reset_state_R7: assert property (@(posedge clk)
    $past(!rst_n) |-> !out_valid && !err);
endmodule

bind vpage_hash vpage_hash_chk #(.PS_W(PS_W), .HASH_W(HASH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .page_shift(page_shift), .out_valid(out_valid), .out_ready(out_ready),
  .hash(hash), .err(err)
);

// File: tb/sim_vpage_hash.sv
module sim_vpage_hash;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, in_valid = 0, seg_1t = 0, out_ready = 1;
  logic [51:0] sid = '0;
  logic [27:0] ea_pn = '0;
  logic [5:0]  page_shift = 6'd12;
  logic        in_ready, out_valid, err;
  logic [38:0] hash;
  int checks = 0, errors = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  vpage_hash u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [38:0] ref_hash(input logic [51:0] s_id, input logic [27:0] pn,
                                           input logic big, input int ps);
    logic [63:0] vpn, s, h;
    if (!big) begin
      vpn = (64'(s_id) << 16) | 64'(pn[15:0]);
      h = (vpn >> 16) ^ ((vpn & 64'hFFFF) >> (ps - 12));
    end else begin
      vpn = (64'(s_id) << 28) | 64'(pn);
      s = vpn >> 28;
      h = s ^ (s << 25) ^ ((vpn & 64'hFFF_FFFF) >> (ps - 12));
    end
    h = h & 64'h7F_FFFF_FFFF;
    return h[38:0];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic next_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
  endtask

  task automatic send(input logic [51:0] s_id, input logic [27:0] pn, input logic big, input int ps,
                      input string req);
    @(negedge clk);
    sid = s_id; ea_pn = pn; seg_1t = big; page_shift = 6'(ps); in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    if (ps < 12) begin
      check({req, "/R4 valid"}, 64'(out_valid), 64'd0);
      check({req, "/R4 err"}, 64'(err), 64'd1);
    end else begin
      check({req, "/R5 valid"}, 64'(out_valid), 64'd1);
      check({req, "/R4 err"}, 64'(err), 64'd0);
      check({req, " hash"}, 64'(hash), 64'(ref_hash(s_id, pn, big, ps)));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 out_valid", 64'(out_valid), 64'd0);
    check("R7 err", 64'(err), 64'd0);
    check("R7 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1;

    send(52'hF_FFFF_FFFF_FFFF, 28'd0, 1'b0, 12, "R3 truncate");
    check("R3 constant", 64'(hash), 64'h7F_FFFF_FFFF);
    send(52'd1, 28'd0, 1'b1, 40, "R2 fold");
    check("R2 constant", 64'(hash), 64'h200_0001);
    send(52'd5, 28'hFFF_FFFF, 1'b0, 28, "R8 256M");
    check("R8 constant", 64'(hash), 64'd5);
    send(52'd3, 28'hFFF_FFFF, 1'b1, 40, "R8 1T");
    check("R8 1T constant", 64'(hash), 64'h600_0003);

    for (int big = 0; big < 2; big++)
      for (int ps = 0; ps < 46; ps++)
        for (int k = 0; k < 4; k++) begin
          next_rng();
          send(rng[51:0], rng[63:36], big[0], ps, big ? "R2 sweep" : "R1 sweep");
        end

    @(negedge clk);
    check("R5 drain", 64'(out_valid), 64'd0);

    out_ready = 0;
    send(52'h1234_5678, 28'h0AB_CDEF, 1'b0, 16, "R6 first");
    check("R6 in_ready low", 64'(in_ready), 64'd0);
    sid = 52'h9; ea_pn = 28'h77; seg_1t = 1; page_shift = 6'd24; in_valid = 1;
    @(negedge clk);
    check("R6 hold valid", 64'(out_valid), 64'd1);
    check("R6 hold hash", 64'(hash), 64'(ref_hash(52'h1234_5678, 28'h0AB_CDEF, 1'b0, 16)));
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R6 next valid", 64'(out_valid), 64'd1);
    check("R6 next hash", 64'(hash), 64'(ref_hash(52'h9, 28'h77, 1'b1, 24)));
    @(negedge clk);
    check("R5 final drain", 64'(out_valid), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule